// File: doc/BRIEF.md
# Converter Output Test-Pattern Generator

This block sits between a data converter's sample path and its output serializer. Each sample clock it produces one output word. The word is either the live converter sample or a deterministic test pattern. A 4-bit mode code selects the source. The patterns cover fixed levels, two-word alternations, two pseudo-random bit streams and a pair of words built from user-programmed bytes. A receiver can use them to confirm that it captures the serial link with the right timing and bit order.

The output is 12 bits wide. A width select shortens every pattern except the pseudo-random ones to 10 bits, placed in the low bits with the upper two bits at zero. A format select converts offset-binary words to two's complement by inverting the most significant bit. The conversion applies only to the level patterns and the pseudo-random patterns; every other mode ignores it. The output is registered, so it follows the inputs sampled at the same clock edge by one cycle.

Top module: `adc_tpg`

## Requirements
- R1: While `rst` is high at a rising edge, `word_out` becomes 0 at that edge.
- R2: Mode codes 0000, 1101, 1110 and 1111 pass `samp_in` straight through in 12-bit mode. In 10-bit mode they output `samp_in[11:2]` in bits 9:0, with bits 11:10 at zero.
- R3: Code 0001 outputs midscale (0x800, or 0x200 in 10-bit mode), code 0010 outputs all ones (0xFFF / 0x3FF) and code 0011 outputs all zeros. In 10-bit mode, every non-PN pattern has bits 11:10 at zero.
- R4: When `twos_sel` is 1, codes 0001 to 0011 invert the word's MSB: bit 11 in 12-bit mode, bit 9 in 10-bit mode.
- R5: Code 0100 alternates 0xAAA and 0x555 (0x2AA / 0x155). Code 0111 alternates all ones and all zeros. Each starts with its first word on the first cycle after reset or a mode change. Neither responds to `twos_sel`.
- R6: Code 0110 outputs a PN9 stream (x^9+x^5+1, new bit = s[8]^s[4], shifted into bit 0). The register is seeded with all ones and makes 12 shifts per cycle. The first bit generated in a cycle goes to bit 11.
- R7: Code 0101 outputs a PN23 stream (x^23+x^18+1, new bit = s[22]^s[17]). It is built the same way as R6.
- R8: The PN modes always output a full 12-bit word, whatever `narrow_sel` is. When `twos_sel` is 1, they invert bit 11.
- R9: Code 1000 alternates two user words, starting with word A. Word A is {usr_b1, usr_b0[7:4]}, or {usr_b1, usr_b0[7:6]} in 10-bit mode. Word B is formed the same way from usr_b3 and usr_b2. Neither responds to `twos_sel`.
- R10: The following codes output fixed words and ignore `twos_sel`: 1001 gives 0xAAA / 0x2AA, 1010 gives 0x03F / 0x01F, 1011 gives 0x800 / 0x200, and 1100 gives 0xA33 / 0x263.
- R11: When `mode_sel` differs from the mode used in the previous cycle, both PN registers are reseeded with all ones and the alternation restarts at the first word, in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 4 | Pattern mode code |
| narrow_sel | input | 1 | 1 = 10-bit words, 0 = 12-bit words |
| twos_sel | input | 1 | 1 = two's complement for modes that honour format |
| usr_b0 | input | 8 | User byte, low part of word A |
| usr_b1 | input | 8 | User byte, high part of word A |
| usr_b2 | input | 8 | User byte, low part of word B |
| usr_b3 | input | 8 | User byte, high part of word B |
| samp_in | input | 12 | Live converter sample |
| word_out | output | 12 | Word to the serializer |

## Verification
The hardest state to reach is a PN register that has been reseeded partway through its stream. The bench gets there by running one PN mode for many cycles, switching briefly to the other, and then coming back, so both streams must restart from the seed and cannot simply resume. A second sweep steps the width and format selects without changing the mode code. This confirms that the phase and the PN stream carry on across those changes, while every mode-code change restarts them.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [3:0] {
    TP_OFF   = 4'h0,
    TP_MID   = 4'h1,
    TP_PFS   = 4'h2,
    TP_NFS   = 4'h3,
    TP_CHK   = 4'h4,
    TP_PNL   = 4'h5,
    TP_PNS   = 4'h6,
    TP_WTOG  = 4'h7,
    TP_USER  = 4'h8,
    TP_BTOG  = 4'h9,
    TP_SYNC  = 4'hA,
    TP_ONEHI = 4'hB,
    TP_MIX   = 4'hC
  } tp_mode_e;

  localparam logic [31:0] MIX_WIDE   = 32'h0000_0A33;
  localparam logic [31:0] MIX_NARROW = 32'h0000_0263;

  // mask of w low ones
  function automatic logic [31:0] low_mask(input int w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r[i] = (i < w);
    return r;
  endfunction

  // alternating bits with the MSB of a w-bit word set
  function automatic logic [31:0] alt_hi(input int w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r[i] = (i < w) && ((i % 2) == ((w - 1) % 2));
    return r;
  endfunction

  function automatic logic [31:0] top_bit(input int w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r[i] = (i == w - 1);
    return r;
  endfunction

  function automatic logic honours_format(input logic [3:0] m);
    return (m == TP_MID) || (m == TP_PFS) || (m == TP_NFS) ||
           (m == TP_PNL) || (m == TP_PNS);
  endfunction

endpackage

// File: rtl/tpg_pn_gen.sv
module tpg_pn_gen #(
  parameter int LEN = 9,
  parameter int TAP = 5,
  parameter int OW  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [OW-1:0] chunk
);

  logic [LEN-1:0] st_q;
  logic [LEN-1:0] walk;
  logic [LEN-1:0] nxt;
  logic           fb;

  always_comb begin
    walk  = restart ? {LEN{1'b1}} : st_q;
    chunk = '0;
    fb    = 1'b0;
    for (int k = 0; k < OW; k++) begin
      fb               = walk[LEN-1] ^ walk[TAP-1];
      chunk[OW-1-k]    = fb;
      walk             = {walk[LEN-2:0], fb};
    end
    nxt = walk;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= {LEN{1'b1}};
    else     st_q <= nxt;
  end

endmodule

// File: rtl/tpg_pattern_sel.sv
module tpg_pattern_sel
  import tpg_pkg::*;
#(
  parameter int DW = 12,
  parameter int NW = 10
) (
  input  logic [3:0]    mode,
  input  logic          narrow,
  input  logic          phase,
  input  logic [7:0]    b0,
  input  logic [7:0]    b1,
  input  logic [7:0]    b2,
  input  logic [7:0]    b3,
  input  logic [DW-1:0] samp,
  input  logic [DW-1:0] pn_short,
  input  logic [DW-1:0] pn_long,
  output logic [DW-1:0] raw,
  output logic          honour,
  output logic          pn_word
);

  localparam logic [DW-1:0] W_ONES = DW'(low_mask(DW));
  localparam logic [DW-1:0] N_ONES = DW'(low_mask(NW));
  localparam logic [DW-1:0] W_ALT  = DW'(alt_hi(DW));
  localparam logic [DW-1:0] N_ALT  = DW'(alt_hi(NW));
  localparam logic [DW-1:0] W_TOP  = DW'(top_bit(DW));
  localparam logic [DW-1:0] N_TOP  = DW'(top_bit(NW));
  localparam logic [DW-1:0] W_SYNC = DW'(low_mask(DW / 2));
  localparam logic [DW-1:0] N_SYNC = DW'(low_mask(NW / 2));
  localparam logic [DW-1:0] W_MIX  = DW'(MIX_WIDE);
  localparam logic [DW-1:0] N_MIX  = DW'(MIX_NARROW);

  logic [DW-1:0] ones_w, alt_w, top_w, sync_w, mix_w, user_w, pass_w;
  logic [15:0]   pair;

  always_comb begin
    ones_w = narrow ? N_ONES : W_ONES;
    alt_w  = narrow ? N_ALT  : W_ALT;
    top_w  = narrow ? N_TOP  : W_TOP;
    sync_w = narrow ? N_SYNC : W_SYNC;
    mix_w  = narrow ? N_MIX  : W_MIX;
    pair   = phase ? {b3, b2} : {b1, b0};
    user_w = narrow ? DW'(pair >> (16 - NW)) : DW'(pair >> (16 - DW));
    pass_w = narrow ? (samp >> (DW - NW)) : samp;
  end

  always_comb begin
    pn_word = 1'b0;
    unique case (mode)
      TP_MID, TP_ONEHI: raw = top_w;
      TP_PFS:           raw = ones_w;
      TP_NFS:           raw = '0;
      TP_CHK:           raw = phase ? (alt_w ^ ones_w) : alt_w;
      TP_WTOG:          raw = phase ? '0 : ones_w;
      TP_BTOG:          raw = alt_w;
      TP_SYNC:          raw = sync_w;
      TP_MIX:           raw = mix_w;
      TP_USER:          raw = user_w;
      TP_PNS: begin
        raw     = pn_short;
        pn_word = 1'b1;
      end
      TP_PNL: begin
        raw     = pn_long;
        pn_word = 1'b1;
      end
      default:          raw = pass_w;
    endcase
    honour = honours_format(mode);
  end

endmodule

// File: rtl/tpg_fmt_apply.sv
module tpg_fmt_apply #(
  parameter int DW = 12,
  parameter int NW = 10
) (
  input  logic [DW-1:0] raw,
  input  logic          honour,
  input  logic          twos,
  input  logic          narrow,
  input  logic          pn_word,
  output logic [DW-1:0] fmt
);

  localparam logic [DW-1:0] W_FLIP = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] N_FLIP = DW'(1) << (NW - 1);

  logic [DW-1:0] flip;

  always_comb begin
    if (!(honour && twos))        flip = '0;
    else if (narrow && !pn_word)  flip = N_FLIP;
    else                          flip = W_FLIP;
    fmt = raw ^ flip;
  end

endmodule

// File: rtl/adc_tpg.sv
module adc_tpg #(
  parameter int DATA_W       = 12,
  parameter int NARROW_W     = 10,
  parameter int PN_LONG_LEN  = 23,
  parameter int PN_LONG_TAP  = 18,
  parameter int PN_SHORT_LEN = 9,
  parameter int PN_SHORT_TAP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode_sel,
  input  logic              narrow_sel,
  input  logic              twos_sel,
  input  logic [7:0]        usr_b0,
  input  logic [7:0]        usr_b1,
  input  logic [7:0]        usr_b2,
  input  logic [7:0]        usr_b3,
  input  logic [DATA_W-1:0] samp_in,
  output logic [DATA_W-1:0] word_out
);

  logic [3:0]        mode_q;
  logic              phase_q;
  logic              restart;
  logic              cur_phase;
  logic [DATA_W-1:0] pn_s, pn_l, raw, word_d;
  logic              honour, pn_word;

  // R11: a new mode code restarts phase and PN seeds in the same cycle
  assign restart   = (mode_sel != mode_q);
  assign cur_phase = restart ? 1'b0 : phase_q;

  tpg_pn_gen #(.LEN(PN_SHORT_LEN), .TAP(PN_SHORT_TAP), .OW(DATA_W)) pn_short_i (
    .clk(clk), .rst(rst), .restart(restart), .chunk(pn_s)
  );

  tpg_pn_gen #(.LEN(PN_LONG_LEN), .TAP(PN_LONG_TAP), .OW(DATA_W)) pn_long_i (
    .clk(clk), .rst(rst), .restart(restart), .chunk(pn_l)
  );

  tpg_pattern_sel #(.DW(DATA_W), .NW(NARROW_W)) sel_i (
    .mode(mode_sel), .narrow(narrow_sel), .phase(cur_phase),
    .b0(usr_b0), .b1(usr_b1), .b2(usr_b2), .b3(usr_b3),
    .samp(samp_in), .pn_short(pn_s), .pn_long(pn_l),
    .raw(raw), .honour(honour), .pn_word(pn_word)
  );

  tpg_fmt_apply #(.DW(DATA_W), .NW(NARROW_W)) fmt_i (
    .raw(raw), .honour(honour), .twos(twos_sel), .narrow(narrow_sel),
    .pn_word(pn_word), .fmt(word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 4'h0;
      phase_q  <= 1'b0;
      word_out <= '0;
    end else begin
      mode_q   <= mode_sel;
      phase_q  <= ~cur_phase;
      word_out <= word_d;
    end
  end

endmodule

// File: rtl/adc_tpg_chk.sv
module adc_tpg_chk #(
  parameter int DATA_W   = 12,
  parameter int NARROW_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        mode_sel,
  input logic              narrow_sel,
  input logic              twos_sel,
  input logic [DATA_W-1:0] samp_in,
  input logic [DATA_W-1:0] word_out
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (word_out == '0)); // R1

  AST_PASS_WIDE: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 4'h0 && !narrow_sel) |=> (word_out == $past(samp_in))); // R2

  AST_NARROW_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (narrow_sel && mode_sel != 4'h5 && mode_sel != 4'h6)
      |=> (word_out[DATA_W-1:NARROW_W] == '0)); // R3

  AST_MID_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 4'h1 && !narrow_sel && !twos_sel)
      |=> (word_out == (DATA_W'(1) << (DATA_W - 1)))); // R3

  AST_FULL_TWOS: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 4'h2 && !narrow_sel && twos_sel)
      |=> (word_out == ({DATA_W{1'b1}} >> 1))); // R4

  AST_WORD_TOGGLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 4'h7 && !narrow_sel)
      |=> (word_out == '0 || word_out == {DATA_W{1'b1}})); // R5

  AST_WORD_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 4'h7 && !narrow_sel) ##1 (mode_sel == 4'h7 && !narrow_sel)
      |=> (word_out != $past(word_out))); // R5

endmodule

bind adc_tpg adc_tpg_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chk_i (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .narrow_sel(narrow_sel),
  .twos_sel(twos_sel), .samp_in(samp_in), .word_out(word_out)
);

// File: tb/adc_tpg_tb_top.sv
module adc_tpg_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mode_sel = 4'h0;
  logic        narrow_sel = 1'b0;
  logic        twos_sel = 1'b0;
  logic [7:0]  usr_b0 = 8'h5C, usr_b1 = 8'hE3, usr_b2 = 8'h17, usr_b3 = 8'h9A;
  logic [11:0] samp_in = '0;
  logic [11:0] word_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [11:0] w;
    string       r;
  } item_t;
  item_t sb_q[$];

  // bench reference state
  logic [3:0]  m_prev;
  logic        m_ph;
  logic [8:0]  m_p9;
  logic [22:0] m_p23;

  always #2ns clk = ~clk;

  adc_tpg dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .narrow_sel(narrow_sel),
    .twos_sel(twos_sel), .usr_b0(usr_b0), .usr_b1(usr_b1), .usr_b2(usr_b2),
    .usr_b3(usr_b3), .samp_in(samp_in), .word_out(word_out)
  );

  function automatic logic [11:0] pn9_word(input logic [8:0] s, output logic [8:0] so);
    logic [11:0] w;
    logic b;
    for (int k = 0; k < 12; k++) begin
      b = s[8] ^ s[4];
      w = {w[10:0], b};
      s = {s[7:0], b};
    end
    so = s;
    return w;
  endfunction

  function automatic logic [11:0] pn23_word(input logic [22:0] s, output logic [22:0] so);
    logic [11:0] w;
    logic b;
    for (int k = 0; k < 12; k++) begin
      b = s[22] ^ s[17];
      w = {w[10:0], b};
      s = {s[21:0], b};
    end
    so = s;
    return w;
  endfunction

  function automatic string req_of(input logic [3:0] m, input bit nar, input bit tw, input bit rs);
    if (rs) return "R11";
    case (m)
      4'h1, 4'h2, 4'h3: return tw ? "R4" : "R3";
      4'h4, 4'h7:       return "R5";
      4'h5:             return (tw || nar) ? "R8" : "R7";
      4'h6:             return (tw || nar) ? "R8" : "R6";
      4'h8:             return "R9";
      4'h9, 4'hA, 4'hB, 4'hC: return "R10";
      default:          return "R2";
    endcase
  endfunction

  task automatic model_reset();
    m_prev = 4'h0;
    m_ph   = 1'b0;
    m_p9   = '1;
    m_p23  = '1;
  endtask

  // driver: called at a falling edge, drives inputs, pushes expectation
  task automatic step(input logic [3:0] m, input bit nar, input bit tw, input logic [11:0] s);
    logic [11:0] e, w9, w23, ua, ub;
    logic [8:0]  n9;
    logic [22:0] n23;
    bit rs;
    item_t it;
    mode_sel = m; narrow_sel = nar; twos_sel = tw; samp_in = s;
    rs = (m != m_prev);
    if (rs) begin m_ph = 1'b0; m_p9 = '1; m_p23 = '1; end
    w9  = pn9_word(m_p9, n9);
    w23 = pn23_word(m_p23, n23);
    ua  = nar ? {2'b00, usr_b1, usr_b0[7:6]} : {usr_b1, usr_b0[7:4]};
    ub  = nar ? {2'b00, usr_b3, usr_b2[7:6]} : {usr_b3, usr_b2[7:4]};
    case (m)
      4'h1: e = nar ? 12'h200 : 12'h800;
      4'h2: e = nar ? 12'h3FF : 12'hFFF;
      4'h3: e = 12'h000;
      4'h4: e = m_ph ? (nar ? 12'h155 : 12'h555) : (nar ? 12'h2AA : 12'hAAA);
      4'h5: e = w23;
      4'h6: e = w9;
      4'h7: e = m_ph ? 12'h000 : (nar ? 12'h3FF : 12'hFFF);
      4'h8: e = m_ph ? ub : ua;
      4'h9: e = nar ? 12'h2AA : 12'hAAA;
      4'hA: e = nar ? 12'h01F : 12'h03F;
      4'hB: e = nar ? 12'h200 : 12'h800;
      4'hC: e = nar ? 12'h263 : 12'hA33;
      default: e = nar ? {2'b00, s[11:2]} : s;
    endcase
    if (tw && (m == 4'h1 || m == 4'h2 || m == 4'h3)) e ^= nar ? 12'h200 : 12'h800;
    if (tw && (m == 4'h5 || m == 4'h6)) e ^= 12'h800;
    it.w = e;
    it.r = req_of(m, nar, tw, rs);
    sb_q.push_back(it);
    m_p9 = n9; m_p23 = n23; m_ph = ~m_ph; m_prev = m;
    @(negedge clk);
  endtask

  task automatic do_reset();
    while (sb_q.size() != 0) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (word_out !== 12'h000) begin
      errors++;
      $display("FAIL R1 reset word actual=%h expected=%h", word_out, 12'h000);
    end
    model_reset();
    rst = 1'b0;
  endtask

  // monitor: pops one expectation per rising edge, samples 1 ns later
  always @(posedge clk) begin
    #1ns;
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (word_out !== it.w) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.r, word_out, it.w);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // sweep every code, both widths, both formats (R2..R10)
    for (int m = 0; m < 16; m++)
      for (int nar = 0; nar < 2; nar++)
        for (int tw = 0; tw < 2; tw++)
          for (int k = 0; k < 5; k++)
            step(4'(m), nar[0], tw[0], 12'($urandom));
    // long PN runs (R6, R7)
    for (int k = 0; k < 60; k++) step(4'h5, 1'b0, 1'b0, 12'h000);
    for (int k = 0; k < 60; k++) step(4'h6, 1'b0, 1'b0, 12'h000);
    // reseed on mode change mid-stream (R11)
    for (int k = 0; k < 3; k++) step(4'h5, 1'b0, 1'b0, 12'h000);
    for (int k = 0; k < 4; k++) step(4'h6, 1'b0, 1'b1, 12'h000);
    for (int k = 0; k < 4; k++) step(4'h5, 1'b1, 1'b0, 12'h000);
    // alternation restart (R11, R5, R9)
    for (int k = 0; k < 3; k++) step(4'h4, 1'b0, 1'b0, 12'h000);
    for (int k = 0; k < 3; k++) step(4'h8, 1'b0, 1'b0, 12'h000);
    for (int k = 0; k < 3; k++) step(4'h4, 1'b1, 1'b1, 12'h000);
    // reset in the middle of a PN run (R1, R6)
    for (int k = 0; k < 5; k++) step(4'h6, 1'b0, 1'b0, 12'h000);
    do_reset();
    for (int k = 0; k < 5; k++) step(4'h6, 1'b0, 1'b0, 12'h000);
    for (int k = 0; k < 4; k++) step(4'hE, 1'b1, 1'b0, 12'hC35);
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule